// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Controller

This block holds and applies the routing state of a broadcast crosspoint with 32 data inputs and 32 data outputs. Two serial ports, each with its own shift clock and data pin, fill two registers. One holds the target output address. The other holds a routing word: a 5-bit source select and a driver-enable bit. An active-low load strobe copies the routing word into the per-output staging register chosen by the address. An active-low configure strobe copies the whole staging file into the active latch in one step. The active latch drives a per-output input multiplexer and a per-output enable flag.

The serial clocks, the data pins and both strobes are sampled in the block's own register clock `clk`. A shift happens on a sampled rising edge of a serial clock. A load happens once on each sampled falling edge of the load strobe. While the configure strobe is held low, the active latch follows the staging file every cycle, so a new load reaches the outputs at once. An output whose enable is clear drives 0 and lowers its enable flag, so an external wired merge of several such blocks can ignore it.

The data path is combinational from `din_i` to `dout_o`. It is a bit-level switch with no packets, so it has no valid/ready handshake and applies no back-pressure.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further programming, every `oen_o` bit is 0 and every `dout_o` bit is 0, whatever `din_i` carries.
- R2: The routing register shifts on each sampled rising edge of `rw_sclk_i`, taking `rw_sdat_i` as its new LSB. After six shifts, the first bit shifted in is the enable bit (1 = driver on) and the next five are the select value, MSB first.
- R3: The address register shifts on each sampled rising edge of `ad_sclk_i`. After five shifts, the first bit shifted in is the address MSB and the last is bit 0.
- R4: A sampled falling edge of `load_n_i` writes the routing word into the staging register named by the address register. Holding `load_n_i` low writes once only, so later changes to the routing register do not reach that staging register until the next falling edge.
- R5: While `cfg_n_i` is high, loads change only the staging file, and `dout_o` and `oen_o` keep their routing.
- R6: A cycle with `cfg_n_i` low copies all 32 staging registers into the active latch together, so several outputs change routing in the same cycle.
- R7: While `cfg_n_i` is held low, a load takes effect on the outputs one `clk` cycle after the load strobe's falling edge is sampled.
- R8: Each enabled output `o` drives `dout_o[o] = din_i[sel]` for its own select value. One input may feed any number of outputs at once.
- R9: An output whose active enable bit is 0 drives `dout_o` = 0 and `oen_o` = 0.
- R10: Reset clears every enable bit in both the staging file and the active latch. A configure strobe after reset with no new loads leaves all outputs disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; samples every control pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_sclk_i | input | 1 | Shift clock of the address port |
| ad_sdat_i | input | 1 | Serial data of the address port, MSB first |
| rw_sclk_i | input | 1 | Shift clock of the routing-word port |
| rw_sdat_i | input | 1 | Serial data of the routing-word port, enable bit first |
| load_n_i | input | 1 | Active-low load strobe, acts on its falling edge |
| cfg_n_i | input | 1 | Active-low configure strobe; the active latch follows the staging file while low |
| din_i | input | 32 | Crosspoint data inputs |
| dout_o | output | 32 | Crosspoint data outputs; 0 when the output is disabled |
| oen_o | output | 32 | Per-output driver-enable flags |

## Verification
The assertions assume that both serial clocks and both strobes change much more slowly than `clk`. Each high or low phase of a serial clock, and each strobe pulse, must last at least one `clk` cycle, so that every edge is sampled. They also assume the serial data pin is already stable in the cycle in which its clock is seen high. The stimulus drives every control pin on the falling edge of `clk`, holds each serial-clock phase for two cycles, holds each strobe low for three cycles, and keeps every strobe high around each release of reset.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned N_IN   = 32;
  localparam int unsigned N_OUT  = 32;
  localparam int unsigned SEL_W  = $clog2(N_IN);
  localparam int unsigned ADDR_W = $clog2(N_OUT);
  localparam int unsigned WORD_W = SEL_W + 1;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } xpt_word_t;
endpackage

// File: rtl/xpt_shift.sv
module xpt_shift #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         sdat_i,
  output logic [W-1:0] word_o
);
  logic         sclk_q;
  logic [W-1:0] sr_q;
  logic         rise;

  assign rise   = sclk_i & ~sclk_q;
  assign word_o = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (rise) sr_q <= {sr_q[W-2:0], sdat_i};
    end
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_i |=> $stable(sr_q)); // R2
endmodule

// File: rtl/xpt_cfg_store.sv
module xpt_cfg_store
  import xpt_pkg::*;
#(
  parameter int unsigned NO = N_OUT,
  parameter int unsigned AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_n_i,
  input  logic               cfg_n_i,
  input  logic [AW-1:0]      addr_i,
  input  xpt_word_t          word_i,
  output xpt_word_t [NO-1:0] act_o
);
  xpt_word_t [NO-1:0] stage_q, stage_nxt, act_q;
  logic               load_q;
  logic               load_fall;
  logic [NO-1:0]      act_en;

  assign load_fall = load_q & ~load_n_i;
  assign act_o     = act_q;

  always_comb begin
    stage_nxt = stage_q;
    if (load_fall && (int'(addr_i) < int'(NO))) stage_nxt[addr_i] = word_i;
  end

  always_comb begin
    for (int i = 0; i < int'(NO); i++) act_en[i] = act_q[i].en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b1;
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      load_q  <= load_n_i;
      stage_q <= stage_nxt;
      if (!cfg_n_i) act_q <= stage_nxt;
    end
  end

  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |=> (act_en == '0)); // R1
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_n_i |=> $stable(act_q)); // R5
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_n_i |=> $stable(stage_q)); // R4
endmodule

// File: rtl/xpt_route.sv
module xpt_route
  import xpt_pkg::*;
#(
  parameter int unsigned NI = N_IN,
  parameter int unsigned NO = N_OUT
) (
  input  xpt_word_t [NO-1:0] act_i,
  input  logic [NI-1:0]      din_i,
  output logic [NO-1:0]      dout_o,
  output logic [NO-1:0]      oen_o
);
  for (genvar o = 0; o < int'(NO); o++) begin : g_out
    assign oen_o[o]  = act_i[o].en;
    assign dout_o[o] = act_i[o].en & din_i[act_i[o].sel];

    always_comb begin
      if (!oen_o[o]) AST_OFF_QUIET: assert (dout_o[o] == 1'b0); // R9
    end
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
#(
  parameter int unsigned NI = N_IN,
  parameter int unsigned NO = N_OUT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ad_sclk_i,
  input  logic          ad_sdat_i,
  input  logic          rw_sclk_i,
  input  logic          rw_sdat_i,
  input  logic          load_n_i,
  input  logic          cfg_n_i,
  input  logic [NI-1:0] din_i,
  output logic [NO-1:0] dout_o,
  output logic [NO-1:0] oen_o
);
  localparam int unsigned AW = $clog2(NO);

  logic [AW-1:0]      addr;
  logic [WORD_W-1:0]  rw_bits;
  xpt_word_t          rw_word;
  xpt_word_t [NO-1:0] act;

  assign rw_word = rw_bits;

  xpt_shift #(.W(AW)) u_ad_sr (
    .clk(clk), .rst_n(rst_n), .sclk_i(ad_sclk_i), .sdat_i(ad_sdat_i), .word_o(addr)
  );

  xpt_shift #(.W(WORD_W)) u_rw_sr (
    .clk(clk), .rst_n(rst_n), .sclk_i(rw_sclk_i), .sdat_i(rw_sdat_i), .word_o(rw_bits)
  );

  xpt_cfg_store #(.NO(NO), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .load_n_i(load_n_i), .cfg_n_i(cfg_n_i),
    .addr_i(addr), .word_i(rw_word), .act_o(act)
  );

  xpt_route #(.NI(NI), .NO(NO)) u_route (
    .act_i(act), .din_i(din_i), .dout_o(dout_o), .oen_o(oen_o)
  );
endmodule

// File: tb/xpt_cfg_ctrl_tb.sv
module xpt_cfg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ad_sclk = 1'b0, ad_sdat = 1'b0;
  logic        rw_sclk = 1'b0, rw_sdat = 1'b0;
  logic        load_n = 1'b1, cfg_n = 1'b1;
  logic [31:0] din = '0;
  logic [31:0] dout, oen;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  xpt_cfg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ad_sclk_i(ad_sclk), .ad_sdat_i(ad_sdat),
    .rw_sclk_i(rw_sclk), .rw_sdat_i(rw_sdat), .load_n_i(load_n), .cfg_n_i(cfg_n),
    .din_i(din), .dout_o(dout), .oen_o(oen)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_addr(logic [4:0] a);
    for (int i = 4; i >= 0; i--) begin
      ad_sdat = a[i]; tick(1);
      ad_sclk = 1'b1; tick(2);
      ad_sclk = 1'b0; tick(2);
    end
  endtask

  task automatic put_word(logic en, logic [4:0] sel);
    logic [5:0] w;
    w = {en, sel};
    for (int i = 5; i >= 0; i--) begin
      rw_sdat = w[i]; tick(1);
      rw_sclk = 1'b1; tick(2);
      rw_sclk = 1'b0; tick(2);
    end
  endtask

  task automatic pulse_load();
    load_n = 1'b0; tick(3); load_n = 1'b1; tick(2);
  endtask

  task automatic pulse_cfg();
    cfg_n = 1'b0; tick(3); cfg_n = 1'b1; tick(2);
  endtask

  task automatic prog(logic [4:0] o, logic en, logic [4:0] sel);
    put_addr(o); put_word(en, sel); pulse_load();
  endtask

  task automatic t_reset();
    din = '1; tick(2);
    chk("R1 oen in reset", oen, 32'h0);
    chk("R1 dout in reset", dout, 32'h0);
    rst_n = 1'b1; tick(3);
    chk("R1 oen after reset", oen, 32'h0);
    chk("R1 dout after reset", dout, 32'h0);
  endtask

  task automatic t_staged();
    prog(5'd3, 1'b1, 5'd7);
    din = 32'h1 << 7; tick(1);
    chk("R5 staged oen", oen, 32'h0);
    chk("R5 staged dout", dout, 32'h0);
    pulse_cfg();
    chk("R6 commit oen", oen, 32'h8);
    chk("R8 route in7->out3", dout, 32'h8);
    din = 32'h0; tick(1);
    chk("R8 route follows din", dout, 32'h0);
  endtask

  task automatic t_multi();
    prog(5'd0,  1'b1, 5'd31);
    prog(5'd31, 1'b1, 5'd0);
    prog(5'd5,  1'b1, 5'd7);
    prog(5'd16, 1'b1, 5'd1);
    chk("R5 held before commit", oen, 32'h8);
    pulse_cfg();
    chk("R6 all commit together", oen, 32'h8001_0029);
    din = 32'h1 << 7; tick(1);
    chk("R8 broadcast in7", dout, 32'h0000_0028);
    din = 32'h1; tick(1);
    chk("R2 select LSB-last order", dout, 32'h8000_0000);
    din = 32'h8000_0000; tick(1);
    chk("R2 select MSB order", dout, 32'h0000_0001);
    din = 32'h2; tick(1);
    chk("R3 address MSB first", dout, 32'h0001_0000);
  endtask

  task automatic t_disable();
    prog(5'd3, 1'b0, 5'd7);
    pulse_cfg();
    din = 32'h1 << 7; tick(1);
    chk("R9 disabled oen", oen & 32'h8, 32'h0);
    chk("R9 disabled dout", dout, 32'h0000_0020);
  endtask

  task automatic t_transparent();
    din = 32'h4;
    cfg_n = 1'b0; tick(2);
    put_addr(5'd10); put_word(1'b1, 5'd2);
    load_n = 1'b0; tick(2);
    chk("R7 transparent oen", oen & 32'h400, 32'h400);
    chk("R7 transparent dout", dout & 32'h400, 32'h400);
    put_word(1'b0, 5'd3); tick(2);
    chk("R4 held strobe writes once", oen & 32'h400, 32'h400);
    load_n = 1'b1; tick(2);
    cfg_n = 1'b1; tick(2);
    chk("R4 no write on rise", oen & 32'h400, 32'h400);
  endtask

  task automatic t_reset_mid();
    din = '1;
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(2);
    chk("R10 reset clears active", oen, 32'h0);
    pulse_cfg();
    chk("R10 staging enables cleared", oen, 32'h0);
    chk("R10 dout quiet", dout, 32'h0);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_staged();
    t_multi();
    t_disable();
    t_transparent();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule